// File: doc/BRIEF.md
# Shift-Based Square Root Estimator

This block gives a fast, approximate integer square root of an unsigned sum, such as the sum of the squared gradient components of a volume sample. It uses no division and no iteration. A leading-one locator counts the effective bits of the operand, which are the bits from the most significant 1 down to bit 0. If that count is odd, the operand is doubled so that the count becomes an even number 2m. The doubled or unchanged operand is then shifted right by m+1 places, and a 1 is placed directly above the top bit of what remains. The result lies within a few percent of the square root of the operand after parity correction.

A parity flag goes out with each result. When the flag is set, the estimate approximates the root of twice the input, and a later stage picks its correction from a separate odd-parity table. A 6-bit table index is also produced: it holds the bits of the estimate just below its leading one, so each parity can select one of 64 entries. A zero input is flagged separately. The block takes one operand per clock when the input strobe is high and returns the registered result one cycle later.

Top module: `shift_sqrt_est`

## Requirements
- R1: `out_odd` is 1 exactly when the effective bit count n of the operand is odd. n is the index of the most significant 1, plus one.
- R2: When n is even, with m = n/2, `out_est` equals 2^(m-1) + floor(A / 2^(m+1)), where A is the input.
- R3: When n is odd, the operand is first doubled. With m = (n+1)/2, `out_est` equals 2^(m-1) + floor(2A / 2^(m+1)).
- R4: For a nonzero input, the leading one of `out_est` sits at bit m-1, so 2^(m-1) <= `out_est` < 2^m.
- R5: A zero input gives `out_zero` = 1, `out_est` = 0, `out_odd` = 0 and `out_idx` = 0. Any nonzero input gives `out_zero` = 0.
- R6: `out_idx` holds the 6 bits of `out_est` directly below its leading one, with the most significant of them at bit 5. When fewer than 6 such bits exist, the lower index bits are filled with 0.
- R7: With A' being the parity-corrected operand (A or 2A), `out_est`^2 * 1000 <= A' * 1126 and (`out_est`+1)^2 > A'.
- R8: A sample accepted at a clock edge with `in_valid` high appears on the outputs after that edge, with `out_valid` = 1.
- R9: After an edge with `in_valid` low, `out_valid` is 0, and `out_est`, `out_idx`, `out_odd` and `out_zero` keep their previous values.
- R10: While `rst_n` is low, `out_valid`, `out_est`, `out_odd`, `out_zero` and `out_idx` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| in_sum | input | 17 | Unsigned operand |
| out_valid | output | 1 | Result strobe, one cycle after the input |
| out_est | output | 9 | Approximate square root |
| out_odd | output | 1 | Effective bit count was odd (operand doubled) |
| out_zero | output | 1 | Operand was zero |
| out_idx | output | 6 | Reciprocal table index |

## Verification
Every result comes from a single register stage. An operand driven before rising edge k is therefore due on every output just after edge k. The bench drives each operand on a falling edge and samples all outputs on the next falling edge, so each comparison falls half a period after the register loads. The sweep presents every 17-bit value back to back, one per cycle, and compares each result against a separate arithmetic model and the accuracy bound. An idle cycle follows, which must drop the result strobe on the next edge and leave the data outputs unchanged.

// File: rtl/sqe_pkg.sv
package sqe_pkg;

    typedef enum logic {
        PAR_EVEN = 1'b0,
        PAR_ODD  = 1'b1
    } parity_e;

endpackage

// File: rtl/sqe_lead_one.sv
module sqe_lead_one
    import sqe_pkg::*;
#(
    parameter int W  = 17,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  opnd,
    output logic [CW-1:0] nbits,
    output parity_e       par,
    output logic          is_zero
);

    always_comb begin
        nbits = '0;
        for (int i = 0; i < W; i++) begin
            if (opnd[i]) nbits = CW'(i + 1);
        end
        par     = nbits[0] ? PAR_ODD : PAR_EVEN;
        is_zero = (nbits == '0);
    end

    // R1: the effective bit count never exceeds the operand width
    always_comb begin
        assert_count_range_R1: assert (nbits <= CW'(W));
    end

endmodule

// File: rtl/sqe_shift_insert.sv
module sqe_shift_insert
    import sqe_pkg::*;
#(
    parameter int W  = 17,
    parameter int CW = $clog2(W + 1),
    parameter int EW = (W + 1) / 2
) (
    input  logic [W-1:0]  opnd,
    input  logic [CW-1:0] nbits,
    input  parity_e       par,
    output logic [CW-1:0] half,
    output logic [EW-1:0] est
);

    logic [W:0] opnd_adj;
    logic [W:0] shifted;

    always_comb begin
        opnd_adj = (par == PAR_ODD) ? {opnd, 1'b0} : {1'b0, opnd};
        half     = CW'((nbits + CW'(par == PAR_ODD)) >> 1);
        shifted  = opnd_adj >> (half + CW'(1));
        est      = EW'(shifted);
        if (half != '0) est = est | (EW'(1) << (half - CW'(1)));
    end

endmodule

// File: rtl/sqe_index.sv
module sqe_index #(
    parameter int EW = 9,
    parameter int CW = 5,
    parameter int IW = 6
) (
    input  logic [EW-1:0] est,
    input  logic [CW-1:0] half,
    output logic [IW-1:0] idx
);

    logic [EW-1:0] aligned;

    always_comb begin
        aligned = est << (CW'(EW) - half);
        idx     = aligned[EW-2 -: IW];
    end

endmodule

// File: rtl/shift_sqrt_est.sv
module shift_sqrt_est
    import sqe_pkg::*;
#(
    parameter int SUM_W = 17,
    parameter int IDX_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [SUM_W-1:0]         in_sum,
    output logic                     out_valid,
    output logic [(SUM_W+1)/2-1:0]   out_est,
    output logic                     out_odd,
    output logic                     out_zero,
    output logic [IDX_W-1:0]         out_idx
);

    localparam int CNT_W = $clog2(SUM_W + 1);
    localparam int EST_W = (SUM_W + 1) / 2;

    typedef struct packed {
        logic             valid;
        logic             zero;
        logic             odd;
        logic [EST_W-1:0] est;
        logic [IDX_W-1:0] idx;
    } res_t;

    res_t st_d, st_q;

    logic [CNT_W-1:0] nbits_w;
    parity_e          par_w;
    logic             zero_w;
    logic [CNT_W-1:0] half_w;
    logic [EST_W-1:0] est_w;
    logic [IDX_W-1:0] idx_w;

    sqe_lead_one #(.W(SUM_W), .CW(CNT_W)) u_lead (
        .opnd    (in_sum),
        .nbits   (nbits_w),
        .par     (par_w),
        .is_zero (zero_w)
    );

    sqe_shift_insert #(.W(SUM_W), .CW(CNT_W), .EW(EST_W)) u_shift (
        .opnd  (in_sum),
        .nbits (nbits_w),
        .par   (par_w),
        .half  (half_w),
        .est   (est_w)
    );

    sqe_index #(.EW(EST_W), .CW(CNT_W), .IW(IDX_W)) u_idx (
        .est  (est_w),
        .half (half_w),
        .idx  (idx_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.zero = zero_w;
            st_d.odd  = (par_w == PAR_ODD);
            st_d.est  = est_w;
            st_d.idx  = idx_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_zero  = st_q.zero;
    assign out_odd   = st_q.odd;
    assign out_est   = st_q.est;
    assign out_idx   = st_q.idx;

    assert_valid_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_est) && $stable(out_idx) && $stable(out_odd) && $stable(out_zero)));

    assert_zero_fields_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_zero) |-> (out_est == '0 && out_idx == '0 && !out_odd));

    assert_zero_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_zero == ($past(in_sum) == '0)));

    assert_nonzero_est_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_zero) |-> (out_est != '0));

endmodule

// File: tb/shift_sqrt_est_test.sv
`timescale 1ns/1ps
module shift_sqrt_est_test;

    localparam int SUM_W = 17;
    localparam int EST_W = (SUM_W + 1) / 2;
    localparam int IDX_W = 6;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               in_valid;
    logic [SUM_W-1:0]   in_sum;
    logic               out_valid;
    logic [EST_W-1:0]   out_est;
    logic               out_odd;
    logic               out_zero;
    logic [IDX_W-1:0]   out_idx;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    shift_sqrt_est #(.SUM_W(SUM_W), .IDX_W(IDX_W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sum    (in_sum),
        .out_valid (out_valid),
        .out_est   (out_est),
        .out_odd   (out_odd),
        .out_zero  (out_zero),
        .out_idx   (out_idx)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // arithmetic model of the requirements
    task automatic model(input int a, output int est, output int odd, output int idx,
                         output int zero, output int aprime, output int m);
        int n, t, cnt, frac, fb;
        n = 0;
        t = a;
        while (t > 0) begin
            n++;
            t = t / 2;
        end
        zero = (a == 0) ? 1 : 0;
        est = 0; odd = 0; idx = 0; aprime = 0; m = 0;
        if (a != 0) begin
            odd    = n % 2;
            aprime = odd ? 2 * a : a;
            cnt    = odd ? n + 1 : n;
            m      = cnt / 2;
            est    = (1 << (m - 1)) + aprime / (1 << (m + 1));
            frac   = est - (1 << (m - 1));
            fb     = m - 1;
            idx    = (fb >= IDX_W) ? (frac >> (fb - IDX_W)) : (frac << (IDX_W - fb));
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int e_est, e_odd, e_idx, e_zero, e_ap, e_m;
        int last_est, last_idx, last_odd, last_zero;
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_sum   = '0;
        repeat (4) @(negedge clk);
        // R10: reset state
        check("R10 valid", out_valid, 0);
        check("R10 est", out_est, 0);
        check("R10 odd", out_odd, 0);
        check("R10 zero", out_zero, 0);
        check("R10 idx", out_idx, 0);
        rst_n = 1'b1;

        last_est = 0; last_idx = 0; last_odd = 0; last_zero = 0;
        for (int v = 0; v < (1 << SUM_W); v++) begin
            in_valid = 1'b1;
            in_sum   = SUM_W'(v);
            @(negedge clk);
            model(v, e_est, e_odd, e_idx, e_zero, e_ap, e_m);
            check("R8 valid", out_valid, 1);
            check("R5 zero flag", out_zero, e_zero);
            check("R1 parity", out_odd, e_odd);
            if (e_odd != 0) check("R3 odd estimate", out_est, e_est);
            else            check("R2 even estimate", out_est, e_est);
            check("R6 index", out_idx, e_idx);
            if (v != 0) begin
                check("R4 leading one low", (out_est >= (1 << (e_m - 1))) ? 1 : 0, 1);
                check("R4 leading one high", (out_est < (1 << e_m)) ? 1 : 0, 1);
                check("R7 upper bound",
                      (longint'(out_est) * out_est * 1000 <= longint'(e_ap) * 1126) ? 1 : 0, 1);
                check("R7 lower bound",
                      ((longint'(out_est) + 1) * (longint'(out_est) + 1) > longint'(e_ap)) ? 1 : 0, 1);
            end
            last_est = e_est; last_idx = e_idx; last_odd = e_odd; last_zero = e_zero;
        end

        // R9: idle cycle with a different operand on the input
        in_valid = 1'b0;
        in_sum   = SUM_W'(12345);
        @(negedge clk);
        check("R9 valid drop", out_valid, 0);
        check("R9 est hold", out_est, last_est);
        check("R9 idx hold", out_idx, last_idx);
        check("R9 odd hold", out_odd, last_odd);
        check("R9 zero hold", out_zero, last_zero);

        // R5 and R8: a zero operand after idle
        in_valid = 1'b1;
        in_sum   = '0;
        @(negedge clk);
        check("R8 valid after idle", out_valid, 1);
        check("R5 zero est", out_est, 0);
        check("R5 zero flag", out_zero, 1);
        check("R5 zero idx", out_idx, 0);

        in_valid = 1'b0;
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule